// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block collects interrupt requests on a set of numbered vectors (256 by default) and offers the most urgent eligible one to a processor. Urgency rises with the vector number. Each vector has three state bits: a pending-request bit, an in-service bit and a trigger-mode bit. Vectors fall into classes of sixteen, and the class is the upper four bits of the vector number.

The processor programs a four-bit task priority and a nine-bit spurious-vector register. Bit 8 of the spurious-vector register enables the block, and bits 7:0 give the vector returned when an acknowledge cannot be served. The block derives a processor priority from the task priority and from the highest vector in service. It raises its pending line only for a request whose class is above that priority.

On an acknowledge, the highest pending vector moves from request to in-service, and its number and trigger mode are returned. An end-of-interrupt command retires the highest vector in service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, no vector is requested or in service, task priority is 0, and the spurious-vector register holds 0x0FF. The block is therefore disabled, `irq_pending` is low, and an acknowledge returns 0xFF.
- R2: A set request marks the vector pending. It records the trigger mode as 1 for level and 0 for edge, and a repeated request overwrites the recorded mode. `ack_level` returns the recorded mode of the acknowledged vector, and returns 0 for a spurious return.
- R3: An acknowledge that is served takes the highest-numbered pending vector. `ack_vec` shows it from the clock edge at which `ack` was sampled.
- R4: `irq_pending` is low whenever bit 8 of the spurious-vector register is 0, whatever is pending.
- R5: A pending request is withheld from `irq_pending` when the processor priority is nonzero and the request's class (vector bits 7:4) is less than or equal to the processor priority class (bits 7:4).
- R6: The processor priority equals the task priority when the task priority class is at least the class of the highest in-service vector. Otherwise it is that in-service class with a zero low nibble. With nothing in service, the in-service class counts as 0.
- R7: If task priority is nonzero and the highest pending vector is numerically at or below it, an acknowledge returns the low byte of the spurious-vector register and changes no request or in-service bit. The comparison uses the full vector number, not the class.
- R8: An acknowledge with nothing pending returns the low byte of the spurious-vector register, and `irq_pending` stays low.
- R9: An end-of-interrupt clears only the highest in-service bit, which can re-enable lower classes. With nothing in service it has no effect.
- R10: A task priority write stores the four-bit value in bits 7:4, with zeros in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (INIT) |
| req_valid | input | 1 | Set-request strobe |
| req_vec | input | 8 | Vector of the request |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_data | input | 4 | Task priority value |
| svr_wr | input | 1 | Spurious-vector register write strobe |
| svr_data | input | 9 | Bit 8 enable, bits 7:0 spurious vector |
| irq_pending | output | 1 | An eligible request is waiting |
| ack_vec | output | 8 | Vector returned by the last acknowledge |
| ack_level | output | 1 | Trigger mode of the last acknowledged vector |

## Verification
The hardest state to reach is one where the in-service class, not the task priority, sets the processor priority while requests wait in the same class and in the class above. This needs a vector acknowledged under a lower task priority, followed by new requests on both sides of its class. Directed steps build that nesting first, and then check the acknowledge corner where a request is withheld from the pending line but still served because its full number exceeds the task priority. A long random mix of requests, acknowledges, end-of-interrupts and register writes then stacks several in-service levels and compares every cycle against a bench model.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   typedef enum logic [1:0] {
      ACK_IDLE  = 2'd0,
      ACK_SPUR  = 2'd1,
      ACK_TAKE  = 2'd2
   } ack_kind_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned NUM_BITS  = 256,
   parameter int unsigned WORD_W    = 32,
   parameter bit          TWO_LEVEL = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_BITS),
   localparam int unsigned BIT_W    = $clog2(WORD_W),
   localparam int unsigned NUM_WORDS = NUM_BITS / WORD_W
) (
   input  logic [NUM_BITS-1:0] bits,
   output logic                any,
   output logic [IDX_W-1:0]    idx
);
   if (NUM_BITS % WORD_W != 0) begin : g_bad_word
      $error("NUM_BITS must be a multiple of WORD_W");
   end
   if ((1 << BIT_W) != WORD_W) begin : g_bad_pow
      $error("WORD_W must be a power of two");
   end

   if (TWO_LEVEL) begin : g_two
      logic [NUM_WORDS-1:0]       word_any;
      logic [NUM_WORDS*BIT_W-1:0] word_idx;

      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         logic [WORD_W-1:0] slice;
         logic [BIT_W-1:0]  loc_idx;
         assign slice = bits[w*WORD_W +: WORD_W];
         always_comb begin
            loc_idx = '0;
            for (int b = 0; b < WORD_W; b++) begin
               if (slice[b]) loc_idx = BIT_W'(b);
            end
         end
         assign word_any[w] = |slice;
         assign word_idx[w*BIT_W +: BIT_W] = loc_idx;
      end

      always_comb begin
         idx = '0;
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_any[w]) begin
               idx = IDX_W'(w * WORD_W) | IDX_W'(word_idx[w*BIT_W +: BIT_W]);
            end
         end
      end
      assign any = |word_any;
   end else begin : g_flat
      always_comb begin
         idx = '0;
         for (int b = 0; b < NUM_BITS; b++) begin
            if (bits[b]) idx = IDX_W'(b);
         end
      end
      assign any = |bits;
   end
endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
   parameter int unsigned NUM_VEC = 256,
   localparam int unsigned IDX_W  = $clog2(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [IDX_W-1:0]   set_idx,
   input  logic               set_level,
   input  logic               take_en,
   input  logic [IDX_W-1:0]   take_idx,
   input  logic               retire_en,
   input  logic [IDX_W-1:0]   retire_idx,
   output logic [NUM_VEC-1:0] irr_q,
   output logic [NUM_VEC-1:0] isr_q,
   output logic [NUM_VEC-1:0] tmr_q
);
   logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;

   always_comb begin
      irr_d = irr_q;
      isr_d = isr_q;
      tmr_d = tmr_q;
      if (take_en)   irr_d[take_idx]   = 1'b0;
      if (set_en) begin
         irr_d[set_idx] = 1'b1;
         tmr_d[set_idx] = set_level;
      end
      if (retire_en) isr_d[retire_idx] = 1'b0;
      if (take_en)   isr_d[take_idx]   = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
         tmr_q <= '0;
      end else begin
         irr_q <= irr_d;
         isr_q <= isr_d;
         tmr_q <= tmr_d;
      end
   end

   // R2: a request leaves its bit pending with the mode it carried
   p_set_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> irr_q[$past(set_idx)] && (tmr_q[$past(set_idx)] == $past(set_level)));

   // R3: a served vector lands in service
   p_take_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |=> isr_q[$past(take_idx)]);

   // R3: a served vector leaves the request set unless re-requested
   p_take_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_en && !(set_en && set_idx == take_idx)) |=> !irr_q[$past(take_idx)]);

   // R9: retiring removes exactly one in-service bit
   p_retire_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_en && !take_en && isr_q[retire_idx])
         |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned CLASS_W = 4,
   localparam int unsigned SUB_W  = IDX_W - CLASS_W
) (
   input  logic [IDX_W-1:0] tpr,
   input  logic             enable,
   input  logic             irr_any,
   input  logic [IDX_W-1:0] irr_idx,
   input  logic             isr_any,
   input  logic [IDX_W-1:0] isr_idx,
   output logic [IDX_W-1:0] ppr,
   output logic             deliver,
   output logic             ack_ok
);
   if (CLASS_W == 0 || CLASS_W >= IDX_W) begin : g_bad_cls
      $error("CLASS_W must lie strictly between 0 and IDX_W");
   end

   logic [CLASS_W-1:0] isr_cls, tpr_cls, irr_cls, ppr_cls;
   logic               suppress, tpr_block;

   assign isr_cls = isr_any ? isr_idx[IDX_W-1 -: CLASS_W] : '0;
   assign tpr_cls = tpr[IDX_W-1 -: CLASS_W];
   assign irr_cls = irr_idx[IDX_W-1 -: CLASS_W];

   always_comb begin
      if (tpr_cls >= isr_cls) ppr = tpr;
      else                    ppr = {isr_cls, {SUB_W{1'b0}}};
   end

   assign ppr_cls   = ppr[IDX_W-1 -: CLASS_W];
   assign suppress  = (ppr != '0) && (irr_cls <= ppr_cls);
   assign deliver   = enable && irr_any && !suppress;
   assign tpr_block = (tpr != '0) && (irr_idx <= tpr);
   assign ack_ok    = irr_any && !tpr_block;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int unsigned NUM_VEC   = 256,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned CLASS_W   = 4,
   parameter bit          TWO_LEVEL = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_VEC),
   localparam int unsigned SVR_W    = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [IDX_W-1:0]   req_vec,
   input  logic               req_level,
   input  logic               ack,
   input  logic               eoi,
   input  logic               tpr_wr,
   input  logic [CLASS_W-1:0] tpr_data,
   input  logic               svr_wr,
   input  logic [SVR_W-1:0]   svr_data,
   output logic               irq_pending,
   output logic [IDX_W-1:0]   ack_vec,
   output logic               ack_level
);
   import irq_prio_pkg::*;

   if ((1 << IDX_W) != NUM_VEC) begin : g_bad_num
      $error("NUM_VEC must be a power of two");
   end

   logic [IDX_W-1:0]   tpr_q;
   logic [SVR_W-1:0]   svr_q;
   logic [NUM_VEC-1:0] irr, isr, tmr;
   logic               irr_any, isr_any, deliver, ack_ok;
   logic [IDX_W-1:0]   irr_idx, isr_idx, ppr;
   ack_kind_e          ack_kind;
   logic               take_en, retire_en;

   irq_prio_enc #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .TWO_LEVEL(TWO_LEVEL)) u_irr_enc (
      .bits(irr), .any(irr_any), .idx(irr_idx));

   irq_prio_enc #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .TWO_LEVEL(TWO_LEVEL)) u_isr_enc (
      .bits(isr), .any(isr_any), .idx(isr_idx));

   irq_prio_resolve #(.IDX_W(IDX_W), .CLASS_W(CLASS_W)) u_resolve (
      .tpr(tpr_q), .enable(svr_q[IDX_W]),
      .irr_any(irr_any), .irr_idx(irr_idx),
      .isr_any(isr_any), .isr_idx(isr_idx),
      .ppr(ppr), .deliver(deliver), .ack_ok(ack_ok));

   always_comb begin
      if (!ack)        ack_kind = ACK_IDLE;
      else if (ack_ok) ack_kind = ACK_TAKE;
      else             ack_kind = ACK_SPUR;
   end

   assign take_en   = (ack_kind == ACK_TAKE);
   assign retire_en = eoi && isr_any;

   irq_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_en(req_valid), .set_idx(req_vec), .set_level(req_level),
      .take_en(take_en), .take_idx(irr_idx),
      .retire_en(retire_en), .retire_idx(isr_idx),
      .irr_q(irr), .isr_q(isr), .tmr_q(tmr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpr_q     <= '0;
         svr_q     <= {1'b0, {IDX_W{1'b1}}};
         ack_vec   <= '0;
         ack_level <= 1'b0;
      end else begin
         if (tpr_wr) tpr_q <= {tpr_data, {(IDX_W-CLASS_W){1'b0}}};
         if (svr_wr) svr_q <= svr_data;
         case (ack_kind)
            ACK_TAKE: begin
               ack_vec   <= irr_idx;
               ack_level <= tmr[irr_idx];
            end
            ACK_SPUR: begin
               ack_vec   <= svr_q[IDX_W-1:0];
               ack_level <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign irq_pending = deliver;

   // R4: disabled block never signals
   p_pend_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !svr_q[IDX_W] |-> !irq_pending);

   // R8: pending line needs a request behind it
   p_pend_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending |-> (irr != '0));

   // R6: processor priority never drops below task priority
   p_ppr_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ppr >= tpr_q);

   // R7: a refused acknowledge leaves requests and service untouched
   p_refused_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ack_ok && !req_valid && !eoi) |=> ($stable(irr) && $stable(isr)));

   // R8: empty acknowledge returns the programmed spurious byte
   p_spur_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !irr_any) |=> (ack_vec == $past(svr_q[IDX_W-1:0])));
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_vec = '0;
   logic       req_level = 1'b0;
   logic       ack = 1'b0;
   logic       eoi = 1'b0;
   logic       tpr_wr = 1'b0;
   logic [3:0] tpr_data = '0;
   logic       svr_wr = 1'b0;
   logic [8:0] svr_data = '0;
   logic       irq_pending;
   logic [7:0] ack_vec;
   logic       ack_level;

   always #5 clk = ~clk;

   irq_prio_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
      .ack(ack), .eoi(eoi),
      .tpr_wr(tpr_wr), .tpr_data(tpr_data),
      .svr_wr(svr_wr), .svr_data(svr_data),
      .irq_pending(irq_pending), .ack_vec(ack_vec), .ack_level(ack_level));

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
   logic [7:0]   m_tpr = '0;
   logic [8:0]   m_svr = 9'h0FF;

   function automatic int hi(input logic [255:0] v);
      for (int i = 255; i >= 0; i--) if (v[i]) return i;
      return -1;
   endfunction

   function automatic logic [7:0] m_ppr();
      int iv = hi(m_isr);
      logic [7:0] isrv = (iv < 0) ? 8'h00 : 8'(iv);
      if (m_tpr[7:4] >= isrv[7:4]) return m_tpr;
      return {isrv[7:4], 4'h0};
   endfunction

   function automatic logic m_pend();
      int iv = hi(m_irr);
      logic [7:0] p = m_ppr();
      logic [7:0] rv;
      if (!m_svr[8] || iv < 0) return 1'b0;
      rv = 8'(iv);
      if (p != 8'h00 && rv[7:4] <= p[7:4]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // kind: 0 request, 1 acknowledge, 2 end-of-interrupt, 3 task priority, 4 spurious register
   task automatic op(input int kind, input logic [7:0] v, input logic lvl,
                     input logic [8:0] d, input string tag);
      int iv;
      logic [7:0] e_vec;
      logic       e_lvl;
      e_vec = 8'h00;
      e_lvl = 1'b0;
      case (kind)
         0: begin
            req_valid = 1'b1; req_vec = v; req_level = lvl;
            m_irr[v] = 1'b1; m_tmr[v] = lvl;
         end
         1: begin
            ack = 1'b1;
            iv = hi(m_irr);
            if (iv < 0 || (m_tpr != 8'h00 && iv <= int'(m_tpr))) begin
               e_vec = m_svr[7:0];
               e_lvl = 1'b0;
            end else begin
               e_vec = 8'(iv);
               e_lvl = m_tmr[iv];
               m_irr[iv] = 1'b0;
               m_isr[iv] = 1'b1;
            end
         end
         2: begin
            eoi = 1'b1;
            iv = hi(m_isr);
            if (iv >= 0) m_isr[iv] = 1'b0;
         end
         3: begin
            tpr_wr = 1'b1; tpr_data = d[3:0];
            m_tpr = {d[3:0], 4'h0};
         end
         default: begin
            svr_wr = 1'b1; svr_data = d;
            m_svr = d;
         end
      endcase
      @(negedge clk);
      req_valid = 1'b0; ack = 1'b0; eoi = 1'b0; tpr_wr = 1'b0; svr_wr = 1'b0;
      chk({tag, " pending"}, int'(irq_pending), int'(m_pend()));
      if (kind == 1) begin
         chk({tag, " ack_vec"}, int'(ack_vec), int'(e_vec));
         chk({tag, " ack_level"}, int'(ack_level), int'(e_lvl));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20417));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 reset pending", int'(irq_pending), 0);
      op(1, 8'h00, 1'b0, 9'h000, "R1");          // returns 0xFF
      op(0, 8'h45, 1'b0, 9'h000, "R4");          // disabled: no pending
      op(4, 8'h00, 1'b0, 9'h13C, "R4");          // enable, spurious 0x3C
      op(0, 8'h80, 1'b1, 9'h000, "R2");
      op(1, 8'h00, 1'b0, 9'h000, "R3");          // 0x80, level
      op(2, 8'h00, 1'b0, 9'h000, "R9");          // retire 0x80, 0x45 pending again
      op(2, 8'h00, 1'b0, 9'h000, "R9");          // nothing in service
      op(3, 8'h00, 1'b0, 9'h004, "R10");         // tpr 0x40: class 4 withheld (R5)
      op(1, 8'h00, 1'b0, 9'h000, "R7");          // 0x45 > 0x40: still served
      op(2, 8'h00, 1'b0, 9'h000, "R9");
      op(0, 8'h3F, 1'b0, 9'h000, "R2");
      op(1, 8'h00, 1'b0, 9'h000, "R7");          // 0x3F <= 0x40: spurious 0x3C
      op(3, 8'h00, 1'b0, 9'h000, "R10");
      op(1, 8'h00, 1'b0, 9'h000, "R7");          // now served 0x3F
      op(2, 8'h00, 1'b0, 9'h000, "R9");
      op(3, 8'h00, 1'b0, 9'h005, "R6");          // tpr 0x50
      op(0, 8'h62, 1'b1, 9'h000, "R6");
      op(1, 8'h00, 1'b0, 9'h000, "R6");          // 0x62 in service, ppr 0x60
      op(0, 8'h65, 1'b0, 9'h000, "R5");          // same class: withheld
      op(0, 8'h71, 1'b0, 9'h000, "R5");          // higher class: pending
      op(0, 8'h71, 1'b1, 9'h000, "R2");          // mode overwritten to level
      op(1, 8'h00, 1'b0, 9'h000, "R2");          // 0x71 level
      op(2, 8'h00, 1'b0, 9'h000, "R9");          // retire 0x71 only
      op(2, 8'h00, 1'b0, 9'h000, "R9");          // retire 0x62
      op(3, 8'h00, 1'b0, 9'h000, "R10");
      op(1, 8'h00, 1'b0, 9'h000, "R3");          // 0x65
      op(2, 8'h00, 1'b0, 9'h000, "R9");
      op(1, 8'h00, 1'b0, 9'h000, "R8");          // drains last (0x00 none left? served or spurious)
      op(1, 8'h00, 1'b0, 9'h000, "R8");          // empty: spurious 0x3C
      op(4, 8'h00, 1'b0, 9'h0A7, "R4");          // disable
      op(0, 8'hF0, 1'b0, 9'h000, "R4");
      op(4, 8'h00, 1'b0, 9'h1A7, "R4");

      for (int n = 0; n < 4000; n++) begin
         int r = $urandom % 100;
         if (r < 40)      op(0, 8'($urandom), 1'($urandom), 9'h000, "R2");
         else if (r < 65) op(1, 8'h00, 1'b0, 9'h000, "R3");
         else if (r < 85) op(2, 8'h00, 1'b0, 9'h000, "R9");
         else if (r < 93) op(3, 8'h00, 1'b0, 9'($urandom % 16), "R10");
         else             op(4, 8'h00, 1'b0, {1'(($urandom % 10) != 0), 8'($urandom)}, "R4");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule